// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that completes every instruction in one clock cycle. It supports six instructions: register add, register subtract, OR with a 16-bit immediate, word load, word store and branch-on-equal. All work is done by one combinational path that starts at the program counter and ends at the storage elements. Fixed multiplexers, set by an instruction decoder, pick the destination register, the second ALU operand, how the immediate is extended, and where the write-back value comes from.

The core contains a 32 x 32-bit register file with two read ports and one write port, a 256-word instruction memory, a 256-word data memory, an ALU and the next-PC logic. The instruction memory is loaded through a write port while reset is held. The outputs show the register write, the memory store and the operand-equality flag of the instruction now executing, so an outside observer can follow the architectural state cycle by cycle.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 and neither `rf_we_o` nor `dm_we_o` is asserted. In the first cycle after `rst` falls, `pc_o` is still 0.
- R2: Register add (opcode 0x00, funct 0x21) writes R[rs]+R[rt], modulo 2^32, to rd. The instruction word splits into opcode in 31:26, rs in 25:21, rt in 20:16, rd in 15:11, funct in 5:0 and immediate in 15:0.
- R3: Register subtract (opcode 0x00, funct 0x23) writes R[rs]-R[rt], modulo 2^32, to rd.
- R4: OR-immediate (opcode 0x0D) zero-extends the immediate, ORs it with R[rs] and writes the result to rt.
- R5: Load (opcode 0x23) writes to rt the data word at byte address R[rs] plus the sign-extended immediate.
- R6: Store (opcode 0x2B) writes R[rt] to the data word at byte address R[rs] plus the sign-extended immediate. A store never writes the register file.
- R7: `equal_o` is high exactly when R[rs] equals R[rt]. Branch-on-equal (opcode 0x04) sets the next PC to PC+4+4*sext(imm) when the two are equal, and to PC+4 otherwise. Every other instruction sets the next PC to PC+4.
- R8: Register 0 always reads as zero. A write aimed at it is presented on the outputs but leaves no trace.
- R9: Reads see the register values from before the current cycle's write, so an instruction whose destination is also its source uses the old value.
- R10: Any other opcode, and opcode 0x00 with any other funct, writes nothing and advances the PC by 4.
- R11: Both memories index words by bits 9:2 of the byte address, so byte addresses that differ only above bit 9 alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every storage element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory load strobe |
| imem_addr | input | 8 | Word index for the instruction load |
| imem_wdata | input | 32 | Instruction word to load |
| pc_o | output | 32 | Byte address of the executing instruction |
| rf_we_o | output | 1 | Register write enable of this cycle |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data memory store enable of this cycle |
| dm_addr_o | output | 32 | Effective byte address from the ALU |
| dm_wdata_o | output | 32 | Store data (second register operand) |
| equal_o | output | 1 | First and second register operands are equal |

## Verification
The program uses an OR-immediate with bit 15 set, which tells zero extension from sign extension. It uses a subtraction that wraps below zero, and negative load/store offsets, which tell sign extension from zero extension. It forms effective addresses above bit 9, which shows whether the memory index is taken from bits 9:2. A write to register 0 followed by a read of it shows whether the write was discarded, and a self-referencing add shows whether reads see the old value. A taken forward branch over two writes, a not-taken branch, a taken backward self-loop, an undefined opcode and an undefined funct check each next-PC path and the no-op case.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

   localparam logic [5:0] OPC_REG  = 6'h00;
   localparam logic [5:0] OPC_BEQ  = 6'h04;
   localparam logic [5:0] OPC_ORI  = 6'h0D;
   localparam logic [5:0] OPC_LOAD = 6'h23;
   localparam logic [5:0] OPC_STOR = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h21;
   localparam logic [5:0] FN_SUB = 6'h23;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    dst_is_rd;   // write register: rd (1) or rt (0)
      logic    b_is_imm;    // second ALU operand: immediate (1) or register (1'b0)
      logic    imm_signed;  // immediate extension: sign (1) or zero (0)
      logic    wb_from_mem; // write-back: memory (1) or ALU (0)
      logic    mem_store;
      logic    reg_write;
      logic    is_branch;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_cpu_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl
);

   always_comb begin
      ctl = '0;
      ctl.alu_op = ALU_ADD;
      case (opcode)
         OPC_REG: begin
            if (funct == FN_ADD || funct == FN_SUB) begin
               ctl.dst_is_rd = 1'b1;
               ctl.reg_write = 1'b1;
               ctl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
            end
         end
         OPC_ORI: begin
            ctl.b_is_imm  = 1'b1;
            ctl.reg_write = 1'b1;
            ctl.alu_op    = ALU_OR;
         end
         OPC_LOAD: begin
            ctl.b_is_imm    = 1'b1;
            ctl.imm_signed  = 1'b1;
            ctl.wb_from_mem = 1'b1;
            ctl.reg_write   = 1'b1;
         end
         OPC_STOR: begin
            ctl.b_is_imm   = 1'b1;
            ctl.imm_signed = 1'b1;
            ctl.mem_store  = 1'b1;
         end
         OPC_BEQ: begin
            ctl.imm_signed = 1'b1;
            ctl.is_branch  = 1'b1;
            ctl.alu_op     = ALU_SUB;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [AW-1:0]   ra,
   input  logic [AW-1:0]   rb,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd
);

   logic [XLEN-1:0] regs [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
         assign regs[gi] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (rst)
               regs[gi] <= '0;
            else if (we && wa == AW'(gi))
               regs[gi] <= wd;
         end
      end
   end

   assign rdata_a = regs[ra];
   assign rdata_b = regs[rb];

   // R9: a write is visible to reads from the following cycle on
   p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
      (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

   // R8: register 0 never takes on a written value
   p_zero_held_r8: assert property (@(posedge clk) disable iff (rst)
      (we && wa == '0) |=> (rdata_a == '0 || ra != '0));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_cpu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);

   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
   import sc_cpu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int NREG   = 32,
   parameter int MEM_AW = 8,
   localparam int RAW    = $clog2(NREG),
   localparam int IDX_HI = MEM_AW + 1,
   localparam int DEPTH  = 1 << MEM_AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              imem_we,
   input  logic [MEM_AW-1:0] imem_addr,
   input  logic [XLEN-1:0]   imem_wdata,
   output logic [XLEN-1:0]   pc_o,
   output logic              rf_we_o,
   output logic [RAW-1:0]    rf_waddr_o,
   output logic [XLEN-1:0]   rf_wdata_o,
   output logic              dm_we_o,
   output logic [XLEN-1:0]   dm_addr_o,
   output logic [XLEN-1:0]   dm_wdata_o,
   output logic              equal_o
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_cpu: instruction fields require XLEN of 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc_cpu: 5-bit register fields require NREG of 32");
   end
   if (MEM_AW < 2 || MEM_AW > 12) begin : g_bad_aw
      $error("sc_cpu: MEM_AW must lie in 2..12");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
   logic [XLEN-1:0] imem [DEPTH];
   logic [XLEN-1:0] dmem [DEPTH];
   logic [XLEN-1:0] instr;
   logic [5:0]      f_op, f_fn;
   logic [RAW-1:0]  f_rs, f_rt, f_rd;
   logic [15:0]     f_imm;
   ctrl_t           ctl;
   logic [XLEN-1:0] bus_a, bus_b, imm_ext, alu_b, alu_y, mem_rd, bus_w;
   logic [RAW-1:0]  wr_reg;
   logic            wr_en, st_en, ops_equal, take_branch;

   // fetch
   assign instr = imem[pc_q[IDX_HI:2]];
   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_fn  = instr[5:0];
   assign f_imm = instr[15:0];

   always_ff @(posedge clk) begin
      if (imem_we)
         imem[imem_addr] <= imem_wdata;
   end

   sc_decode u_decode (
      .opcode (f_op),
      .funct  (f_fn),
      .ctl    (ctl)
   );

   assign wr_reg = ctl.dst_is_rd ? f_rd : f_rt;
   assign wr_en  = ctl.reg_write & ~rst;
   assign st_en  = ctl.mem_store & ~rst;

   sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
      .clk     (clk),
      .rst     (rst),
      .ra      (f_rs),
      .rb      (f_rt),
      .rdata_a (bus_a),
      .rdata_b (bus_b),
      .we      (wr_en),
      .wa      (wr_reg),
      .wd      (bus_w)
   );

   assign imm_ext = ctl.imm_signed ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                   : {{(XLEN-16){1'b0}}, f_imm};
   assign alu_b   = ctl.b_is_imm ? imm_ext : bus_b;

   sc_alu #(.XLEN(XLEN)) u_alu (
      .a  (bus_a),
      .b  (alu_b),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   // data memory: read combinational, write on the clock edge
   assign mem_rd = dmem[alu_y[IDX_HI:2]];
   always_ff @(posedge clk) begin
      if (st_en)
         dmem[alu_y[IDX_HI:2]] <= bus_b;
   end

   assign bus_w = ctl.wb_from_mem ? mem_rd : alu_y;

   // next PC
   assign ops_equal   = (bus_a == bus_b);
   assign take_branch = ctl.is_branch & ops_equal;
   assign pc_plus4    = pc_q + XLEN'(4);
   assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign pc_next     = take_branch ? br_target : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   assign pc_o       = pc_q;
   assign rf_we_o    = wr_en;
   assign rf_waddr_o = wr_reg;
   assign rf_wdata_o = bus_w;
   assign dm_we_o    = st_en;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = bus_b;
   assign equal_o    = ops_equal;

   // R1: the first cycle out of reset fetches from address 0
   always_ff @(posedge clk) begin
      if (!rst && $past(rst))
         p_pc_cleared_r1: assert (pc_q == '0);
   end

   // R6: a store and a register write never share a cycle
   p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
      dm_we_o |-> !rf_we_o);

   // R7: without a taken branch the PC steps by one word
   p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
      !take_branch |=> (pc_q == $past(pc_q) + XLEN'(4)));

   // R7: a taken branch lands on the offset target
   p_branch_dest_r7: assert property (@(posedge clk) disable iff (rst)
      take_branch |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));

endmodule

// File: tb/sc_cpu_bench.sv
module sc_cpu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RUN_CYCLES = 40;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        imem_we = 1'b0;
   logic [7:0]  imem_addr = '0;
   logic [31:0] imem_wdata = '0;
   logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic [4:0]  rf_waddr_o;
   logic        rf_we_o, dm_we_o, equal_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_cpu u_sc_cpu (
      .clk        (clk),
      .rst        (rst),
      .imem_we    (imem_we),
      .imem_addr  (imem_addr),
      .imem_wdata (imem_wdata),
      .pc_o       (pc_o),
      .rf_we_o    (rf_we_o),
      .rf_waddr_o (rf_waddr_o),
      .rf_wdata_o (rf_wdata_o),
      .dm_we_o    (dm_we_o),
      .dm_addr_o  (dm_addr_o),
      .dm_wdata_o (dm_wdata_o),
      .equal_o    (equal_o)
   );

   // reference state
   logic [31:0] m_reg  [32];
   logic [31:0] m_dmem [256];
   logic [31:0] m_imem [256];
   logic [31:0] m_pc;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   function automatic string with_zero(string base, int rs, int rt, int wa, bit we);
      if (rs == 0 || rt == 0 || (we && wa == 0))
         return {base, " R8"};
      return base;
   endfunction

   string pc_tag = "R1";

   // one cycle of the reference: compare outputs, then retire
   task automatic step_model();
      logic [31:0] ins, a, b, sx, addr, wd, nxt;
      logic [5:0]  op, fn;
      int          rs, rt, rd, wa;
      bit          we, st, eq;
      string       tag;
      ins = m_imem[m_pc[9:2]];
      op  = ins[31:26];
      fn  = ins[5:0];
      rs  = int'(ins[25:21]);
      rt  = int'(ins[20:16]);
      rd  = int'(ins[15:11]);
      a   = m_reg[rs];
      b   = m_reg[rt];
      sx  = {{16{ins[15]}}, ins[15:0]};
      eq  = (a == b);
      nxt = m_pc + 32'd4;
      we = 1'b0; st = 1'b0; wa = 0; wd = '0; addr = '0;
      tag = "R10";
      case (op)
         6'h00: begin
            if (fn == 6'h21) begin
               we = 1'b1; wa = rd; wd = a + b; tag = "R2";
            end else if (fn == 6'h23) begin
               we = 1'b1; wa = rd; wd = a - b; tag = "R3";
            end
            if (we && (rd == rs || rd == rt)) tag = {tag, " R9"};
         end
         6'h0D: begin
            we = 1'b1; wa = rt; wd = a | {16'h0, ins[15:0]}; tag = "R4";
         end
         6'h23: begin
            addr = a + sx; we = 1'b1; wa = rt; wd = m_dmem[addr[9:2]];
            tag = "R5 R11";
         end
         6'h2B: begin
            addr = a + sx; st = 1'b1; tag = "R6 R11";
         end
         6'h04: begin
            if (eq) nxt = m_pc + 32'd4 + (sx << 2);
            tag = "R7";
         end
         default: ;
      endcase
      tag = with_zero(tag, rs, rt, wa, we);

      check(pc_tag, "pc", pc_o, m_pc);
      check("R7", "equal", {31'd0, equal_o}, {31'd0, eq});
      check(tag, "reg write enable", {31'd0, rf_we_o}, {31'd0, we});
      check(tag, "store enable", {31'd0, dm_we_o}, {31'd0, st});
      if (we) begin
         check(tag, "write register", {27'd0, rf_waddr_o}, wa[31:0]);
         check(tag, "write data", rf_wdata_o, wd);
      end
      if (st) begin
         check(tag, "store address", dm_addr_o, addr);
         check(tag, "store data", dm_wdata_o, b);
      end

      if (we && wa != 0) m_reg[wa] = wd;
      if (st) m_dmem[addr[9:2]] = b;
      m_pc   = nxt;
      pc_tag = (op == 6'h04) ? "R7" : "R7 R10";
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         m_imem[i] = '0;
         m_dmem[i] = '0;
      end
      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      m_pc = '0;

      m_imem[0]  = enc_i(6'h0D, 0, 1, 16'h8005);   // ori r1 = 0x8005 (zero-ext)
      m_imem[1]  = enc_i(6'h0D, 0, 2, 16'h0003);
      m_imem[2]  = enc_r(1, 2, 3, 6'h21);          // add
      m_imem[3]  = enc_r(2, 1, 4, 6'h23);          // sub wraps below zero
      m_imem[4]  = enc_i(6'h2B, 0, 3, 16'h0010);   // store word 4
      m_imem[5]  = enc_i(6'h2B, 1, 4, 16'hFFFC);   // 0x8001 aliases word 0
      m_imem[6]  = enc_i(6'h0D, 0, 5, 16'h0414);
      m_imem[7]  = enc_i(6'h23, 5, 6, 16'hFFFC);   // 0x410 aliases word 4
      m_imem[8]  = enc_i(6'h23, 0, 7, 16'h0000);
      m_imem[9]  = enc_r(1, 2, 0, 6'h21);          // write to r0
      m_imem[10] = enc_r(0, 1, 8, 6'h21);          // read r0
      m_imem[11] = enc_r(1, 1, 1, 6'h21);          // self-referencing add
      m_imem[12] = enc_r(1, 0, 10, 6'h23);
      m_imem[13] = enc_i(6'h04, 6, 3, 16'h0002);   // taken forward
      m_imem[14] = enc_i(6'h0D, 0, 11, 16'hDEAD);  // skipped
      m_imem[15] = enc_i(6'h0D, 0, 12, 16'hBEEF);  // skipped
      m_imem[16] = enc_i(6'h04, 1, 2, 16'h0005);   // not taken
      m_imem[17] = {6'h3F, 26'h3FF_FFFF};          // unknown opcode
      m_imem[18] = enc_r(1, 2, 13, 6'h20);         // unknown funct
      m_imem[19] = enc_i(6'h2B, 5, 10, 16'h0000);
      m_imem[20] = enc_i(6'h23, 0, 14, 16'h0014);
      m_imem[21] = enc_i(6'h04, 0, 0, 16'hFFFF);   // taken backward self-loop

      for (int i = 0; i < 22; i++) begin
         @(negedge clk);
         imem_we    = 1'b1;
         imem_addr  = 8'(i);
         imem_wdata = m_imem[i];
      end
      @(negedge clk);
      imem_we = 1'b0;
      @(negedge clk);
      #1;
      // R1: outputs quiet while in reset
      check("R1", "pc in reset", pc_o, 32'd0);
      check("R1", "reg write in reset", {31'd0, rf_we_o}, 32'd0);
      check("R1", "store in reset", {31'd0, dm_we_o}, 32'd0);

      @(negedge clk);
      rst = 1'b0;
      #1;
      for (int c = 0; c < RUN_CYCLES; c++) begin
         step_model();
         @(negedge clk);
         #1;
      end

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule